// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register File

This block is the processor-facing register file of a two-channel asynchronous serial controller. Software reaches it over a byte-wide register bus made of an address, a read strobe and a write strobe. For each channel there is a command register, a status register, a transmit holding register and a receive buffer. Shared interrupt status, mask and vector registers drive a single interrupt request. The bit serializers, the baud generator, the counter/timer and the mode registers lie outside the block. Their addresses are still decoded, so writes to them have no effect here.

Each channel exchanges bytes with its serializer on two streams. On the receive side, the serializer presents `rx_valid` with a byte, and the register file asserts `rx_ready` only while that channel's receiver is enabled and its buffer is empty. A byte is transferred on a cycle where both are high. While `rx_ready` is low the serializer must hold the byte or drop it. The receive stream is back-pressured by the unread buffer, and software releases it by reading the buffer. The transmit side has no ready input. `tx_valid` pulses for one cycle per accepted write, and software paces its writes through the status bits.

Top module: `dual_serial_regs`

## Requirements
- R1: After reset, both receivers and both transmitters are disabled, and every readable register (status of both channels, interrupt status, mask, vector) returns 0x00. `rx_ready`, `tx_valid` and `irq` are low.
- R2: In a command write, bits 1:0 control the receiver: 01 enables it, 10 disables it, and 00 or 11 leave it unchanged. The receiver state is seen at `rx_ready`.
- R3: In a command write, bits 3:2 control the transmitter. 01 enables it and sets status bit 2 (TX-ready), status bit 3 (TX-empty) and the channel's TX interrupt status bit. 10 disables it and clears all three. 00 and 11 change nothing.
- R4: A channel's `rx_ready` equals receiver-enabled AND status bit 0 (RX-ready) clear. When `rx_valid` and `rx_ready` are both high at a clock edge, the byte is latched, and status bit 0 and the channel's RX interrupt status bit are set. At any other time `rx_valid` has no effect.
- R5: A read of a channel's data address returns the latched byte in the same cycle, and at the clock edge it clears status bit 0 and the RX interrupt status bit. If a byte is accepted in the same cycle, the new byte wins and both bits stay set.
- R6: A write to a channel's data address while its transmitter is enabled raises `tx_valid` for exactly the next cycle, with the written byte on `tx_data`. While the transmitter is disabled the write is ignored.
- R7: `irq` is high exactly when (interrupt status AND mask) is nonzero. `irq_level` reads 4 while `irq` is high and 0 otherwise. `irq_vector` shows the vector register.
- R8: Address map (hex): channel A status 03, command 05, data 07. Channel B status 13, command 15, data 17. Interrupt status (read-only) 0B, mask 0D, vector 19. Interrupt status bits: 0 = A TX-ready, 1 = A RX-full, 4 = B TX-ready, 5 = B RX-full. All other bits read 0.
- R9: Reads of unmapped addresses, of the mode addresses (01, 11) and of the auxiliary control address (09) return 0x00. Writes to the mode, clock-select (03, 13), auxiliary control and interrupt status addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register address |
| bus_rd | input | 1 | Read strobe; data valid the same cycle, side effects at the edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when no read) |
| rx_valid | input | 2 | Per-channel received byte valid |
| rx_data | input | 16 | Per-channel received byte, channel n at bits 8n+7:8n |
| rx_ready | output | 2 | Per-channel receive accept |
| tx_valid | output | 2 | Per-channel one-cycle transmit byte strobe |
| tx_data | output | 16 | Per-channel transmit byte, channel n at bits 8n+7:8n |
| irq | output | 1 | Interrupt request |
| irq_level | output | 3 | Priority level, 4 while requesting |
| irq_vector | output | 8 | Programmed interrupt vector |

## Verification
The receive-full flag is visible at `rx_ready`, at status bit 0 and at the RX interrupt bit. If it is lost or stuck, the next check after the edge where it changes sees it, through a wrong `rx_ready` or a wrong `irq` once the mask selects that bit. A transmitter enable that is latched wrongly shows up on the first data write after it, as a missing or extra `tx_valid` pulse one cycle later. A corrupted receive or vector latch shows up at the next read of that register or directly on `irq_vector`. The bench compares every port after every bus operation, so a divergence is reported within one operation of its cause.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  // per-channel offsets within a channel window
  localparam int unsigned CH_STRIDE = 16;
  localparam int unsigned OFS_MODE  = 1;
  localparam int unsigned OFS_STAT  = 3;
  localparam int unsigned OFS_CMD   = 5;
  localparam int unsigned OFS_DATA  = 7;
  // shared registers
  localparam int unsigned ADR_AUX   = 9;
  localparam int unsigned ADR_ISR   = 11;
  localparam int unsigned ADR_MASK  = 13;
  localparam int unsigned ADR_VEC   = 25;
  // status bit positions
  localparam int unsigned SB_RXRDY  = 0;
  localparam int unsigned SB_TXRDY  = 2;
  localparam int unsigned SB_TXEMP  = 3;

  typedef enum logic [1:0] {
    FLD_KEEP = 2'b00,
    FLD_ON   = 2'b01,
    FLD_OFF  = 2'b10,
    FLD_RSV  = 2'b11
  } fld_e;

  function automatic int unsigned isr_tx_bit(input int unsigned ch);
    return 4 * ch;
  endfunction

  function automatic int unsigned isr_rx_bit(input int unsigned ch);
    return 4 * ch + 1;
  endfunction
endpackage

// File: rtl/dsr_chan.sv
module dsr_chan
  import dsr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic          data_we,
  input  logic          data_re,
  input  logic [DW-1:0] wdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic [7:0]    status,
  output logic [DW-1:0] rx_byte,
  output logic          ev_tx_set,
  output logic          ev_tx_clr,
  output logic          ev_rx_set,
  output logic          ev_rx_clr
);
  fld_e rx_fld, tx_fld;
  logic rx_en, tx_en, full, txrdy, accept, txv_q;
  logic [DW-1:0] rx_buf, tx_q;

  assign rx_fld   = fld_e'(wdata[1:0]);
  assign tx_fld   = fld_e'(wdata[3:2]);
  assign rx_ready = rx_en & ~full;
  assign accept   = rx_valid & rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
      txrdy <= 1'b0;
    end else if (cmd_we) begin
      case (rx_fld)
        FLD_ON:  rx_en <= 1'b1;
        FLD_OFF: rx_en <= 1'b0;
        default: ;
      endcase
      case (tx_fld)
        FLD_ON:  begin tx_en <= 1'b1; txrdy <= 1'b1; end
        FLD_OFF: begin tx_en <= 1'b0; txrdy <= 1'b0; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      rx_buf <= '0;
    end else if (accept) begin
      full   <= 1'b1;
      rx_buf <= rx_data;
    end else if (data_re) begin
      full   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txv_q <= 1'b0;
      tx_q  <= '0;
    end else begin
      txv_q <= data_we & tx_en;
      if (data_we & tx_en) tx_q <= wdata;
    end
  end

  assign tx_valid = txv_q;
  assign tx_data  = tx_q;
  assign rx_byte  = rx_buf;

  always_comb begin
    status           = '0;
    status[SB_RXRDY] = full;
    status[SB_TXRDY] = txrdy;
    status[SB_TXEMP] = txrdy;
  end

  assign ev_tx_set = cmd_we & (tx_fld == FLD_ON);
  assign ev_tx_clr = cmd_we & (tx_fld == FLD_OFF);
  assign ev_rx_set = accept;
  assign ev_rx_clr = data_re;

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[SB_RXRDY] && !data_re) |=> ($stable(rx_byte) && status[SB_RXRDY]));

  assert_rx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_re && !rx_valid) |=> !status[SB_RXRDY]);

  assert_tx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(data_we) && $past(status[SB_TXRDY])));
endmodule

// File: rtl/dsr_irq.sv
module dsr_irq
  import dsr_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int DW       = 8,
  parameter int LVL_W    = 3,
  parameter int IRQ_LVL  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic             vec_we,
  input  logic [DW-1:0]    wdata,
  input  logic [NCH-1:0]   tx_set,
  input  logic [NCH-1:0]   tx_clr,
  input  logic [NCH-1:0]   rx_set,
  input  logic [NCH-1:0]   rx_clr,
  output logic [DW-1:0]    isr,
  output logic [DW-1:0]    mask,
  output logic [DW-1:0]    vec,
  output logic             irq,
  output logic [LVL_W-1:0] irq_level
);
  logic [NCH-1:0] txf, rxf;

  for (genvar c = 0; c < NCH; c++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        txf[c] <= 1'b0;
        rxf[c] <= 1'b0;
      end else begin
        if (tx_set[c])      txf[c] <= 1'b1;
        else if (tx_clr[c]) txf[c] <= 1'b0;
        if (rx_set[c])      rxf[c] <= 1'b1;
        else if (rx_clr[c]) rxf[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    isr = '0;
    for (int c = 0; c < NCH; c++) begin
      isr[isr_tx_bit(c)] = txf[c];
      isr[isr_rx_bit(c)] = rxf[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      vec  <= '0;
    end else begin
      if (mask_we) mask <= wdata;
      if (vec_we)  vec  <= wdata;
    end
  end

  assign irq       = |(isr & mask);
  assign irq_level = irq ? LVL_W'(IRQ_LVL) : '0;

  assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask == $past(wdata)));
endmodule

// File: rtl/dual_serial_regs.sv
module dual_serial_regs
  import dsr_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DW     = 8,
  parameter int ADDR_W = 6,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    rx_valid,
  input  logic [NCH*DW-1:0] rx_data,
  output logic [NCH-1:0]    rx_ready,
  output logic [NCH-1:0]    tx_valid,
  output logic [NCH*DW-1:0] tx_data,
  output logic              irq,
  output logic [LVL_W-1:0]  irq_level,
  output logic [DW-1:0]     irq_vector
);
  localparam logic [ADDR_W-1:0] A_ISR  = ADDR_W'(ADR_ISR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADR_MASK);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(ADR_VEC);

  logic [NCH-1:0] cmd_we, data_we, data_re, stat_re;
  logic [NCH-1:0] ev_tx_set, ev_tx_clr, ev_rx_set, ev_rx_clr;
  logic [7:0]     status [NCH];
  logic [DW-1:0]  rx_byte [NCH];
  logic [DW-1:0]  isr, mask, vec;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(c * CH_STRIDE + OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(c * CH_STRIDE + OFS_CMD);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(c * CH_STRIDE + OFS_DATA);

    assign cmd_we[c]  = bus_wr & (bus_addr == A_CMD);
    assign data_we[c] = bus_wr & (bus_addr == A_DATA);
    assign data_re[c] = bus_rd & (bus_addr == A_DATA);
    assign stat_re[c] = bus_rd & (bus_addr == A_STAT);

    dsr_chan #(.DW(DW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_we    (cmd_we[c]),
      .data_we   (data_we[c]),
      .data_re   (data_re[c]),
      .wdata     (bus_wdata),
      .rx_valid  (rx_valid[c]),
      .rx_data   (rx_data[c*DW +: DW]),
      .rx_ready  (rx_ready[c]),
      .tx_valid  (tx_valid[c]),
      .tx_data   (tx_data[c*DW +: DW]),
      .status    (status[c]),
      .rx_byte   (rx_byte[c]),
      .ev_tx_set (ev_tx_set[c]),
      .ev_tx_clr (ev_tx_clr[c]),
      .ev_rx_set (ev_rx_set[c]),
      .ev_rx_clr (ev_rx_clr[c])
    );

    assert_txflag_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      isr[isr_tx_bit(c)] == status[c][SB_TXRDY]);

    assert_rxflag_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      isr[isr_rx_bit(c)] == status[c][SB_RXRDY]);
  end

  dsr_irq #(.NCH(NCH), .DW(DW), .LVL_W(LVL_W), .IRQ_LVL(4)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we   (bus_wr & (bus_addr == A_MASK)),
    .vec_we    (bus_wr & (bus_addr == A_VEC)),
    .wdata     (bus_wdata),
    .tx_set    (ev_tx_set),
    .tx_clr    (ev_tx_clr),
    .rx_set    (ev_rx_set),
    .rx_clr    (ev_rx_clr),
    .isr       (isr),
    .mask      (mask),
    .vec       (vec),
    .irq       (irq),
    .irq_level (irq_level)
  );

  assign irq_vector = vec;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == A_ISR)  bus_rdata = isr;
      if (bus_addr == A_MASK) bus_rdata = mask;
      if (bus_addr == A_VEC)  bus_rdata = vec;
      for (int c = 0; c < NCH; c++) begin
        if (stat_re[c]) bus_rdata = DW'(status[c]);
        if (data_re[c]) bus_rdata = rx_byte[c];
      end
    end
  end
endmodule

// File: tb/sim_dual_serial_regs.sv
module sim_dual_serial_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [1:0]  rx_valid = '0, rx_ready, tx_valid;
  logic [15:0] rx_data = '0, tx_data;
  logic        irq;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // bench model
  bit       m_rxen [2], m_full [2], m_txen [2], m_txv [2];
  logic [7:0] m_byte [2], m_txd [2];
  logic [7:0] m_mask, m_vec;

  always #5 clk = ~clk;

  dual_serial_regs u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input int c);
    return {4'b0, m_txen[c], m_txen[c], 1'b0, m_full[c]};
  endfunction

  function automatic logic [7:0] exp_isr();
    return {2'b0, m_full[1], m_txen[1], 2'b0, m_full[0], m_txen[0]};
  endfunction

  function automatic logic [7:0] exp_read(input logic [5:0] a);
    case (a)
      6'h03: return exp_status(0);
      6'h13: return exp_status(1);
      6'h07: return m_byte[0];
      6'h17: return m_byte[1];
      6'h0B: return exp_isr();
      6'h0D: return m_mask;
      6'h19: return m_vec;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk_all();
    for (int c = 0; c < 2; c++) begin
      check("R2/R4 rx_ready", rx_ready[c], m_rxen[c] && !m_full[c]);
      check("R6 tx_valid", tx_valid[c], m_txv[c]);
      if (m_txv[c]) check("R6 tx_data", tx_data[c*8 +: 8], m_txd[c]);
    end
    check("R7 irq", irq, |(exp_isr() & m_mask));
    check("R7 irq_level", irq_level, (|(exp_isr() & m_mask)) ? 3'd4 : 3'd0);
    check("R7 irq_vector", irq_vector, m_vec);
  endtask

  task automatic do_wr(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    m_txv[0] = 0; m_txv[1] = 0;
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      if (a == 6'(c*16 + 5)) begin
        if (d[1:0] == 2'b01) m_rxen[c] = 1;
        if (d[1:0] == 2'b10) m_rxen[c] = 0;
        if (d[3:2] == 2'b01) m_txen[c] = 1;
        if (d[3:2] == 2'b10) m_txen[c] = 0;
      end
      if (a == 6'(c*16 + 7) && m_txen[c]) begin
        m_txv[c] = 1; m_txd[c] = d;
      end
    end
    if (a == 6'h0D) m_mask = d;
    if (a == 6'h19) m_vec = d;
    @(negedge clk);
    bus_wr = 1'b0;
    chk_all();
  endtask

  task automatic do_rd(input logic [5:0] a, input logic [1:0] push, input logic [15:0] pd);
    string tag;
    bus_addr = a; bus_rd = 1'b1; rx_valid = push; rx_data = pd;
    m_txv[0] = 0; m_txv[1] = 0;
    #1;
    case (a)
      6'h03, 6'h13: tag = "R3/R4 status read";
      6'h07, 6'h17: tag = "R5 data read";
      6'h0B: tag = "R8 isr read";
      6'h0D, 6'h19: tag = "R7 mask/vector read";
      default: tag = "R9 unmapped read";
    endcase
    check(tag, bus_rdata, exp_read(a));
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      bit acc;
      acc = push[c] && m_rxen[c] && !m_full[c];
      if (a == 6'(c*16 + 7)) m_full[c] = 0;
      if (acc) begin m_full[c] = 1; m_byte[c] = pd[c*8 +: 8]; end
    end
    @(negedge clk);
    bus_rd = 1'b0; rx_valid = '0;
    chk_all();
  endtask

  task automatic do_push(input logic [1:0] push, input logic [15:0] pd);
    do_rd(6'h3F, push, pd);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 2; c++) begin
      m_rxen[c] = 0; m_full[c] = 0; m_txen[c] = 0; m_txv[c] = 0;
      m_byte[c] = 0; m_txd[c] = 0;
    end
    m_mask = 0; m_vec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rx_ready", rx_ready, 2'b00);
    check("R1 tx_valid", tx_valid, 2'b00);
    check("R1 irq", irq, 1'b0);
    do_rd(6'h03, 2'b00, 16'h0); do_rd(6'h13, 2'b00, 16'h0);
    do_rd(6'h0B, 2'b00, 16'h0); do_rd(6'h0D, 2'b00, 16'h0); do_rd(6'h19, 2'b00, 16'h0);
    // R4 disabled receiver ignores rx_valid
    do_push(2'b11, 16'h1122);
    // R2 enable rx A, R4 accept, R5 read
    do_wr(6'h05, 8'h01);
    do_push(2'b01, 16'h00A5);
    do_push(2'b01, 16'h003C);      // full: ignored (R4)
    do_rd(6'h07, 2'b00, 16'h0);    // R5 returns A5 and clears
    do_rd(6'h03, 2'b00, 16'h0);
    // R5 read and accept in same cycle
    do_rd(6'h07, 2'b01, 16'h0077);
    do_rd(6'h0B, 2'b00, 16'h0);
    // R3 tx B enable, R7 mask/vector
    do_wr(6'h15, 8'h04);
    do_wr(6'h0D, 8'h10);
    do_wr(6'h19, 8'h42);
    do_wr(6'h17, 8'h5A);           // R6 pulse
    do_wr(6'h15, 8'h0F);           // reserved codes: R2/R3 no change
    do_wr(6'h15, 8'h08);           // R3 disable
    do_wr(6'h17, 8'h66);           // R6 ignored
    // R9 writes with no effect
    do_wr(6'h11, 8'hFF); do_wr(6'h13, 8'hFF); do_wr(6'h09, 8'hFF); do_wr(6'h0B, 8'hFF);
    do_rd(6'h11, 2'b00, 16'h0); do_rd(6'h09, 2'b00, 16'h0);
    // R2 disable rx A
    do_wr(6'h05, 8'h02);
    // constrained random mix
    for (int i = 0; i < 1500; i++) begin
      int unsigned k;
      logic [5:0] a;
      k = $urandom % 10;
      a = ($urandom % 2 == 0) ? 6'h00 : 6'h10;
      case (k)
        0, 1: do_wr(a | 6'h05, 8'($urandom));
        2:    do_wr(a | 6'h07, 8'($urandom));
        3:    do_rd(a | 6'h07, 2'($urandom), 16'($urandom));
        4:    do_rd(a | 6'h03, 2'($urandom), 16'($urandom));
        5:    do_rd(6'h0B, 2'($urandom), 16'($urandom));
        6:    do_wr(($urandom % 2) ? 6'h0D : 6'h19, 8'($urandom));
        7:    do_rd(6'($urandom), 2'($urandom), 16'($urandom));
        default: do_push(2'($urandom), 16'($urandom));
      endcase
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule